// File: doc/BRIEF.md
# Four-Way Instruction Address Translator with Pairwise-Order Replacement

This block is a small, fully associative instruction-side translation buffer with four slots. Each slot holds a virtual page number, an address-space tag, a valid flag, a shared flag, a two-bit page-size code, a physical page number, two protection bits and a cacheable flag. A lookup compares a 32-bit virtual address against every slot at once. It returns hit, multiple-hit, the index of the matching slot, the 29-bit physical address and the slot's attributes.

Replacement follows a 6-bit pairwise-order word. Each pair of slots owns one bit of this word, which records which slot of the pair was used more recently. A lookup that hits exactly one slot marks that slot as most recent. A refill from the larger unified buffer carries a complete entry, is always written into the slot the order word names as least recent, and marks that slot as most recent too. A global invalidate drops every slot in one cycle.

Lookups are a valid/ready stream. The response comes from a one-deep register and is also valid/ready. The refill port is valid/ready. Invalidate and the replacement-state outputs are plain pins.

Top module: `itlb_four`

## Requirements
- R1: A slot matches a lookup only when its valid flag is 1 and one of these holds: its shared flag is 1, `lk_asid_en` is 0, or its tag equals `lk_asid`.
- R2: The size code selects the page size: 0 is 1 KB, 1 is 4 KB, 2 is 64 KB and 3 is 1 MB. Virtual address bits below that size are left out of the comparison with the stored page number, whose bit 0 stands for address bit 10.
- R3: When more than one slot matches, the response shows `rsp_multi`=1 and `rsp_hit`=0, and the order word does not change.
- R4: On a single match, `rsp_pa` takes its bits above the page size from the slot's physical page number shifted left by 10, and its bits below the page size from the virtual address. `rsp_idx`, `rsp_pr`, `rsp_c` and `rsp_sz` show that slot.
- R5: A single hit or a refill of slot 0 clears order bits [5:3]. For slot 1 it sets [5] and clears [2:1]. For slot 2 it sets [4] and [2] and clears [0]. For slot 3 it sets [3], [1] and [0]. A miss does not change the order word.
- R6: The victim is decided in this order of priority. Slot 0 is chosen when bits [5:3] are 111. Otherwise slot 1 is chosen when [5] is 0 and [2:1] are 11. Otherwise slot 2 is chosen when [4] is 0, [2] is 0 and [0] is 1. Otherwise slot 3 is chosen when [3], [1] and [0] are all 0. An accepted refill is written into the victim slot.
- R7: An order word that fits none of the victim patterns raises `repl_err` and selects slot 0.
- R8: `inv` clears every valid flag at the next edge. While it is high, `fill_ready` and `lk_ready` are 0, so a refill offered in that cycle is dropped.
- R9: A response stays valid and unchanged until it is taken with `rsp_ready`. `lk_ready` is 0 while an untaken response is held and while `fill_valid` is high, so refills take priority over lookups.
- R10: After reset, every slot is invalid, the order word is 0 (victim slot 3, no error) and no response is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv | input | 1 | Invalidate all slots |
| fill_valid | input | 1 | Refill entry offered |
| fill_ready | output | 1 | Refill can be accepted |
| fill_vpn | input | 22 | Refill virtual page number (address bits 31:10) |
| fill_asid | input | 8 | Refill address-space tag |
| fill_v | input | 1 | Refill valid flag |
| fill_sh | input | 1 | Refill shared flag |
| fill_sz | input | 2 | Refill page-size code |
| fill_ppn | input | 19 | Refill physical page number (address bits 28:10) |
| fill_pr | input | 2 | Refill protection bits |
| fill_c | input | 1 | Refill cacheable flag |
| lk_valid | input | 1 | Lookup offered |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Current address-space tag |
| lk_asid_en | input | 1 | 1 enables tag comparison |
| rsp_valid | output | 1 | Response held |
| rsp_ready | input | 1 | Response taken |
| rsp_hit | output | 1 | Exactly one slot matched |
| rsp_multi | output | 1 | More than one slot matched |
| rsp_idx | output | 2 | Matching slot |
| rsp_pa | output | 29 | Physical address, 0 unless hit |
| rsp_pr | output | 2 | Protection bits of matching slot, 0 unless hit |
| rsp_c | output | 1 | Cacheable flag of matching slot, 0 unless hit |
| rsp_sz | output | 2 | Size code of matching slot, 0 unless hit |
| repl_state | output | 6 | Pairwise-order word |
| repl_victim | output | 2 | Slot the next refill will use |
| repl_err | output | 1 | Order word fits no victim pattern |

## Verification
The assertions check on every cycle that a response is held steady under back-pressure, that a multiple match never also reports a hit and leaves the order word alone, and that a hit or refill of slot 0 clears its three order bits. They also check that an invalid order word points to slot 0 and that invalidate and refill both block the other ports. Only the bench's scenarios can show that the match rules hold: the tag and shared-flag cases, the four page-size boundaries, and physical address assembly. The same is true of the full sequence of order-word updates with the victim each one yields, and of the fact that a refill dropped during invalidate never appears later.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
  localparam int VA_W     = 32;
  localparam int PA_W     = 29;
  localparam int ASID_W   = 8;
  localparam int PAGE_LSB = 10;
  localparam int VPN_W    = VA_W - PAGE_LSB;
  localparam int PPN_W    = PA_W - PAGE_LSB;
  localparam int N_WAYS   = 4;
  localparam int IDX_W    = $clog2(N_WAYS);
  localparam int ORD_W    = N_WAYS * (N_WAYS - 1) / 2;

  typedef struct packed {
    logic              v;
    logic              sh;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [1:0]        sz;
    logic [PPN_W-1:0]  ppn;
    logic [1:0]        pr;
    logic              c;
  } itlb_ent_t;

  // page-number bits that take part in the compare for a size code
  function automatic logic [VPN_W-1:0] vpn_keep(input logic [1:0] sz);
    logic [VPN_W-1:0] m;
    m = '1;
    case (sz)
      2'd1:    m[1:0] = '0;
      2'd2:    m[5:0] = '0;
      2'd3:    m[9:0] = '0;
      default: m = '1;
    endcase
    return m;
  endfunction

  // in-page offset bits of the physical address for a size code
  function automatic logic [PA_W-1:0] ofs_mask(input logic [1:0] sz);
    logic [PA_W-1:0] m;
    m = '0;
    case (sz)
      2'd1:    m[11:0] = '1;
      2'd2:    m[15:0] = '1;
      2'd3:    m[19:0] = '1;
      default: m[9:0]  = '1;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/itlb_order.sv
module itlb_order
  import itlb_pkg::*;
#(
  parameter logic [ORD_W-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [ORD_W-1:0] state,
  output logic [IDX_W-1:0] victim,
  output logic             bad
);
  logic [ORD_W-1:0] set_pat, clr_pat;

  always_comb begin
    case (touch_idx)
      2'd0:    begin set_pat = 6'b000000; clr_pat = 6'b111000; end
      2'd1:    begin set_pat = 6'b100000; clr_pat = 6'b000110; end
      2'd2:    begin set_pat = 6'b010100; clr_pat = 6'b000001; end
      default: begin set_pat = 6'b001011; clr_pat = 6'b000000; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     state <= INIT;
    else if (touch) state <= (state & ~clr_pat) | set_pat;
  end

  always_comb begin
    bad = 1'b0;
    if (state[5:3] == 3'b111)                                victim = 2'd0;
    else if (!state[5] && state[2:1] == 2'b11)               victim = 2'd1;
    else if (!state[4] && !state[2] && state[0])             victim = 2'd2;
    else if (!state[3] && !state[1] && !state[0])            victim = 2'd3;
    else begin
      victim = 2'd0;
      bad    = 1'b1;
    end
  end
endmodule

// File: rtl/itlb_cam.sv
module itlb_cam
  import itlb_pkg::*;
(
  input  itlb_ent_t [N_WAYS-1:0] ents,
  input  logic [VPN_W-1:0]       va_vpn,
  input  logic [ASID_W-1:0]      asid,
  input  logic                   asid_en,
  output logic                   one_hit,
  output logic                   multi,
  output logic [IDX_W-1:0]       idx
);
  logic [N_WAYS-1:0] hv;

  for (genvar g = 0; g < N_WAYS; g++) begin : g_way
    logic [VPN_W-1:0] keep;
    logic             tag_ok;
    assign keep   = vpn_keep(ents[g].sz);
    assign tag_ok = ents[g].sh || !asid_en || (ents[g].asid == asid);
    assign hv[g]  = ents[g].v && tag_ok && ((ents[g].vpn & keep) == (va_vpn & keep));
  end

  always_comb begin
    int unsigned cnt;
    cnt = 0;
    idx = '0;
    for (int i = 0; i < N_WAYS; i++) begin
      if (hv[i]) begin
        cnt = cnt + 1;
        idx = IDX_W'(i);
      end
    end
    one_hit = (cnt == 1);
    multi   = (cnt > 1);
  end
endmodule

// File: rtl/itlb_xlate.sv
module itlb_xlate
  import itlb_pkg::*;
(
  input  itlb_ent_t        ent,
  input  logic             use_ent,
  input  logic [VA_W-1:0]  va,
  output logic [PA_W-1:0]  pa,
  output logic [1:0]       pr,
  output logic             c,
  output logic [1:0]       sz
);
  logic [PA_W-1:0] om, base;

  assign om   = ofs_mask(ent.sz);
  assign base = {ent.ppn, {PAGE_LSB{1'b0}}};

  always_comb begin
    if (use_ent) begin
      pa = (base & ~om) | (va[PA_W-1:0] & om);
      pr = ent.pr;
      c  = ent.c;
      sz = ent.sz;
    end else begin
      pa = '0;
      pr = '0;
      c  = 1'b0;
      sz = '0;
    end
  end
endmodule

// File: rtl/itlb_four.sv
module itlb_four
  import itlb_pkg::*;
#(
  parameter logic [5:0] LRU_INIT = 6'b000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inv,
  input  logic        fill_valid,
  output logic        fill_ready,
  input  logic [21:0] fill_vpn,
  input  logic [7:0]  fill_asid,
  input  logic        fill_v,
  input  logic        fill_sh,
  input  logic [1:0]  fill_sz,
  input  logic [18:0] fill_ppn,
  input  logic [1:0]  fill_pr,
  input  logic        fill_c,
  input  logic        lk_valid,
  output logic        lk_ready,
  input  logic [31:0] lk_va,
  input  logic [7:0]  lk_asid,
  input  logic        lk_asid_en,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic        rsp_hit,
  output logic        rsp_multi,
  output logic [1:0]  rsp_idx,
  output logic [28:0] rsp_pa,
  output logic [1:0]  rsp_pr,
  output logic        rsp_c,
  output logic [1:0]  rsp_sz,
  output logic [5:0]  repl_state,
  output logic [1:0]  repl_victim,
  output logic        repl_err
);
  itlb_ent_t [N_WAYS-1:0] ents;
  itlb_ent_t              fill_ent;
  logic                   fill_fire, lk_fire;
  logic                   c_one, c_multi;
  logic [IDX_W-1:0]       c_idx;
  logic [PA_W-1:0]        x_pa;
  logic [1:0]             x_pr, x_sz;
  logic                   x_c;
  logic                   touch;
  logic [IDX_W-1:0]       touch_idx;

  assign fill_ready = !inv;
  assign lk_ready   = !inv && !fill_valid && (!rsp_valid || rsp_ready);
  assign fill_fire  = fill_valid && fill_ready;
  assign lk_fire    = lk_valid && lk_ready;

  assign fill_ent = '{v: fill_v, sh: fill_sh, asid: fill_asid, vpn: fill_vpn,
                      sz: fill_sz, ppn: fill_ppn, pr: fill_pr, c: fill_c};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ents <= '0;
    end else if (inv) begin
      for (int i = 0; i < N_WAYS; i++) ents[i].v <= 1'b0;
    end else if (fill_fire) begin
      ents[repl_victim] <= fill_ent;
    end
  end

  itlb_cam u_cam (
    .ents    (ents),
    .va_vpn  (lk_va[VA_W-1:PAGE_LSB]),
    .asid    (lk_asid),
    .asid_en (lk_asid_en),
    .one_hit (c_one),
    .multi   (c_multi),
    .idx     (c_idx)
  );

  itlb_xlate u_xlate (
    .ent     (ents[c_idx]),
    .use_ent (c_one),
    .va      (lk_va),
    .pa      (x_pa),
    .pr      (x_pr),
    .c       (x_c),
    .sz      (x_sz)
  );

  assign touch     = fill_fire || (lk_fire && c_one);
  assign touch_idx = fill_fire ? repl_victim : c_idx;

  itlb_order #(.INIT(LRU_INIT)) u_order (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch     (touch),
    .touch_idx (touch_idx),
    .state     (repl_state),
    .victim    (repl_victim),
    .bad       (repl_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_multi <= 1'b0;
      rsp_idx   <= '0;
      rsp_pa    <= '0;
      rsp_pr    <= '0;
      rsp_c     <= 1'b0;
      rsp_sz    <= '0;
    end else if (lk_fire) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= c_one;
      rsp_multi <= c_multi;
      rsp_idx   <= c_idx;
      rsp_pa    <= x_pa;
      rsp_pr    <= x_pr;
      rsp_c     <= x_c;
      rsp_sz    <= x_sz;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/itlb_four_chk.sv
module itlb_four_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        inv,
  input logic        fill_valid,
  input logic        fill_ready,
  input logic        lk_valid,
  input logic        lk_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic        rsp_hit,
  input logic        rsp_multi,
  input logic [1:0]  rsp_idx,
  input logic [28:0] rsp_pa,
  input logic [5:0]  repl_state,
  input logic [1:0]  repl_victim,
  input logic        repl_err
);
  AST_MULTI_NOT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_multi |-> !rsp_hit); // R3
  AST_MULTI_KEEPS_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready |=> !rsp_multi || $stable(repl_state)); // R3
  AST_HIT0_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready |=> !(rsp_hit && rsp_idx == 2'd0) || repl_state[5:3] == 3'b000); // R5
  AST_FILL0_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && fill_ready && repl_victim == 2'd0 |=> repl_state[5:3] == 3'b000); // R6
  AST_BAD_PICKS0: assert property (@(posedge clk) disable iff (!rst_n)
    repl_err |-> repl_victim == 2'd0); // R7
  AST_INV_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    inv |-> !fill_ready && !lk_ready); // R8
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_hit) && $stable(rsp_idx)); // R9
  AST_FILL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> !lk_ready); // R9
endmodule

bind itlb_four itlb_four_chk u_chk (.*);

// File: tb/itlb_four_bench.sv
module itlb_four_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, inv;
  logic        fill_valid, fill_ready, fill_v, fill_sh, fill_c;
  logic [21:0] fill_vpn;
  logic [7:0]  fill_asid;
  logic [1:0]  fill_sz, fill_pr;
  logic [18:0] fill_ppn;
  logic        lk_valid, lk_ready, lk_asid_en;
  logic [31:0] lk_va;
  logic [7:0]  lk_asid;
  logic        rsp_valid, rsp_ready, rsp_hit, rsp_multi, rsp_c;
  logic [1:0]  rsp_idx, rsp_pr, rsp_sz;
  logic [28:0] rsp_pa;
  logic [5:0]  repl_state;
  logic [1:0]  repl_victim;
  logic        repl_err;

  logic        b_fill_ready, b_lk_ready, b_rsp_valid, b_rsp_hit, b_rsp_multi, b_rsp_c, b_err;
  logic [1:0]  b_rsp_idx, b_rsp_pr, b_rsp_sz, b_victim;
  logic [28:0] b_rsp_pa;
  logic [5:0]  b_state;

  itlb_four u_itlb_four (.*);

  itlb_four #(.LRU_INIT(6'b101010)) u_itlb_four_bad (
    .clk(clk), .rst_n(rst_n), .inv(1'b0),
    .fill_valid(1'b0), .fill_ready(b_fill_ready), .fill_vpn(22'd0), .fill_asid(8'd0),
    .fill_v(1'b0), .fill_sh(1'b0), .fill_sz(2'd0), .fill_ppn(19'd0), .fill_pr(2'd0), .fill_c(1'b0),
    .lk_valid(1'b0), .lk_ready(b_lk_ready), .lk_va(32'd0), .lk_asid(8'd0), .lk_asid_en(1'b0),
    .rsp_valid(b_rsp_valid), .rsp_ready(1'b1), .rsp_hit(b_rsp_hit), .rsp_multi(b_rsp_multi),
    .rsp_idx(b_rsp_idx), .rsp_pa(b_rsp_pa), .rsp_pr(b_rsp_pr), .rsp_c(b_rsp_c), .rsp_sz(b_rsp_sz),
    .repl_state(b_state), .repl_victim(b_victim), .repl_err(b_err));

  int n_chk = 0;
  int n_bad = 0;
  logic [5:0] m_ord;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] ord_touch(input logic [5:0] s, input int idx);
    case (idx)
      0:       return s & 6'b000111;
      1:       return (s & 6'b111001) | 6'b100000;
      2:       return (s & 6'b111110) | 6'b010100;
      default: return s | 6'b001011;
    endcase
  endfunction

  function automatic logic [1:0] ord_victim(input logic [5:0] s);
    if (s[5:3] == 3'b111) return 2'd0;
    if (!s[5] && s[2:1] == 2'b11) return 2'd1;
    if (!s[4] && !s[2] && s[0]) return 2'd2;
    return 2'd3;
  endfunction

  function automatic logic [28:0] exp_pa(input logic [18:0] ppn, input logic [1:0] sz, input logic [31:0] va);
    logic [28:0] m;
    case (sz)
      2'd0: m = 29'h3FF;
      2'd1: m = 29'hFFF;
      2'd2: m = 29'hFFFF;
      default: m = 29'hFFFFF;
    endcase
    return ({ppn, 10'd0} & ~m) | (va[28:0] & m);
  endfunction

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic fill(input logic [31:0] va, input logic [7:0] asid, input logic sh,
                      input logic [1:0] sz, input logic [18:0] ppn, input logic [1:0] pr,
                      input logic c, input string req);
    @(negedge clk);
    chk({req, " victim before fill"}, 64'(repl_victim), 64'(ord_victim(m_ord)));
    fill_valid = 1'b1; fill_vpn = va[31:10]; fill_asid = asid; fill_v = 1'b1;
    fill_sh = sh; fill_sz = sz; fill_ppn = ppn; fill_pr = pr; fill_c = c;
    m_ord = ord_touch(m_ord, int'(ord_victim(m_ord)));
    @(negedge clk);
    fill_valid = 1'b0;
    chk({req, " order after fill"}, 64'(repl_state), 64'(m_ord));
  endtask

  task automatic lookup(input logic [31:0] va, input logic [7:0] asid, input logic en);
    @(negedge clk);
    lk_va = va; lk_asid = asid; lk_asid_en = en; lk_valid = 1'b1; rsp_ready = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic expect_hit(input string req, input int idx, input logic [28:0] pa,
                            input logic [1:0] pr, input logic c, input logic [1:0] sz);
    chk({req, " valid"}, 64'(rsp_valid), 64'd1);
    chk({req, " hit"}, 64'(rsp_hit), 64'd1);
    chk({req, " multi"}, 64'(rsp_multi), 64'd0);
    chk({req, " idx"}, 64'(rsp_idx), 64'(idx));
    chk({req, " pa"}, 64'(rsp_pa), 64'(pa));
    chk({req, " pr/c/sz"}, {59'd0, rsp_pr, rsp_c, rsp_sz}, {59'd0, pr, c, sz});
    m_ord = ord_touch(m_ord, idx);
    chk("R5 order after hit", 64'(repl_state), 64'(m_ord));
  endtask

  task automatic expect_miss(input string req);
    chk({req, " valid"}, 64'(rsp_valid), 64'd1);
    chk({req, " hit"}, 64'(rsp_hit), 64'd0);
    chk({req, " multi"}, 64'(rsp_multi), 64'd0);
    chk("R5 order unchanged by miss", 64'(repl_state), 64'(m_ord));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R10 order", 64'(repl_state), 64'd0);
    chk("R10 victim", 64'(repl_victim), 64'd3);
    chk("R10 err", 64'(repl_err), 64'd0);
    lookup(32'h0000_0000, 8'd0, 1'b0);
    expect_miss("R10 empty lookup");
  endtask

  task automatic t_bad_order();
    chk("R7 err flag", 64'(b_err), 64'd1);
    chk("R7 victim", 64'(b_victim), 64'd0);
  endtask

  task automatic t_fills();
    fill(32'h0040_0000, 8'd5, 1'b0, 2'd1, 19'h12345, 2'b10, 1'b1, "R6 A");
    fill(32'h0080_0400, 8'd9, 1'b1, 2'd0, 19'h00111, 2'b01, 1'b0, "R6 B");
    fill(32'h0100_0000, 8'd5, 1'b0, 2'd2, 19'h04440, 2'b11, 1'b1, "R6 C");
    fill(32'h1000_0000, 8'd7, 1'b0, 2'd3, 19'h7FC00, 2'b00, 1'b0, "R6 D");
  endtask

  task automatic t_match();
    lookup(32'h0040_0ABC, 8'd5, 1'b1);
    expect_hit("R1 R4 A", 3, exp_pa(19'h12345, 2'd1, 32'h0040_0ABC), 2'b10, 1'b1, 2'd1);
    lookup(32'h0040_0ABC, 8'd6, 1'b1);
    expect_miss("R1 tag mismatch");
    lookup(32'h0040_0ABC, 8'd6, 1'b0);
    expect_hit("R1 tag check off", 3, exp_pa(19'h12345, 2'd1, 32'h0040_0ABC), 2'b10, 1'b1, 2'd1);
    lookup(32'h0080_04FF, 8'd1, 1'b1);
    expect_hit("R1 shared", 2, exp_pa(19'h00111, 2'd0, 32'h0080_04FF), 2'b01, 1'b0, 2'd0);
  endtask

  task automatic t_sizes();
    lookup(32'h0080_0800, 8'd9, 1'b1);
    expect_miss("R2 1KB edge");
    lookup(32'h0040_1000, 8'd5, 1'b1);
    expect_miss("R2 4KB edge");
    lookup(32'h0100_F123, 8'd5, 1'b1);
    expect_hit("R2 R4 64KB", 1, exp_pa(19'h04440, 2'd2, 32'h0100_F123), 2'b11, 1'b1, 2'd2);
    lookup(32'h0101_0000, 8'd5, 1'b1);
    expect_miss("R2 64KB edge");
    lookup(32'h100F_FFFC, 8'd7, 1'b1);
    expect_hit("R2 R4 1MB", 0, exp_pa(19'h7FC00, 2'd3, 32'h100F_FFFC), 2'b00, 1'b0, 2'd3);
  endtask

  task automatic t_multi();
    fill(32'h1004_0000, 8'd7, 1'b0, 2'd0, 19'h00ABC, 2'b10, 1'b1, "R6 E");
    lookup(32'h1004_0010, 8'd7, 1'b1);
    chk("R3 valid", 64'(rsp_valid), 64'd1);
    chk("R3 multi", 64'(rsp_multi), 64'd1);
    chk("R3 hit", 64'(rsp_hit), 64'd0);
    chk("R3 order kept", 64'(repl_state), 64'(m_ord));
  endtask

  task automatic t_inv();
    @(negedge clk);
    inv = 1'b1;
    fill_valid = 1'b1; fill_vpn = 22'(32'h2000_0000 >> 10); fill_asid = 8'd0; fill_v = 1'b1;
    fill_sh = 1'b1; fill_sz = 2'd0; fill_ppn = 19'h1; fill_pr = 2'b00; fill_c = 1'b0;
    #1;
    chk("R8 fill_ready low", 64'(fill_ready), 64'd0);
    chk("R8 lk_ready low", 64'(lk_ready), 64'd0);
    @(negedge clk);
    inv = 1'b0; fill_valid = 1'b0;
    chk("R8 order kept", 64'(repl_state), 64'(m_ord));
    lookup(32'h100F_FFFC, 8'd7, 1'b1);
    expect_miss("R8 cleared slot");
    lookup(32'h2000_0000, 8'd0, 1'b0);
    expect_miss("R8 dropped refill");
  endtask

  task automatic t_flow();
    logic [1:0] vic;
    @(negedge clk);
    rsp_ready = 1'b0;
    lk_va = 32'h0300_0000; lk_asid = 8'd0; lk_asid_en = 1'b0; lk_valid = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0;
    chk("R9 rsp held", 64'(rsp_valid), 64'd1);
    chk("R9 lk_ready while held", 64'(lk_ready), 64'd0);
    @(negedge clk);
    chk("R9 rsp still held", 64'(rsp_valid), 64'd1);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R9 rsp taken", 64'(rsp_valid), 64'd0);
    vic = ord_victim(m_ord);
    fill_valid = 1'b1; fill_vpn = 22'(32'h0300_0000 >> 10); fill_asid = 8'd3; fill_v = 1'b1;
    fill_sh = 1'b0; fill_sz = 2'd1; fill_ppn = 19'h0ABCD; fill_pr = 2'b11; fill_c = 1'b1;
    lk_valid = 1'b1; lk_va = 32'h0300_0123; lk_asid = 8'd3; lk_asid_en = 1'b1;
    #1;
    chk("R9 lk_ready under refill", 64'(lk_ready), 64'd0);
    m_ord = ord_touch(m_ord, int'(vic));
    @(negedge clk);
    fill_valid = 1'b0; lk_valid = 1'b0;
    chk("R9 lookup not taken", 64'(rsp_valid), 64'd0);
    chk("R6 order after refill", 64'(repl_state), 64'(m_ord));
    lookup(32'h0300_0123, 8'd3, 1'b1);
    expect_hit("R6 refill in victim", int'(vic), exp_pa(19'h0ABCD, 2'd1, 32'h0300_0123), 2'b11, 1'b1, 2'd1);
  endtask

  initial begin
    rst_n = 1'b0; inv = 1'b0; fill_valid = 1'b0; fill_vpn = '0; fill_asid = '0; fill_v = 1'b0;
    fill_sh = 1'b0; fill_sz = '0; fill_ppn = '0; fill_pr = '0; fill_c = 1'b0;
    lk_valid = 1'b0; lk_va = '0; lk_asid = '0; lk_asid_en = 1'b0; rsp_ready = 1'b1;
    m_ord = 6'b000000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bad_order();
    t_fills();
    t_match();
    t_sizes();
    t_multi();
    t_inv();
    t_flow();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule